// File: doc/BRIEF.md
# Zero and Move Idiom Detector

This block sits just ahead of a register renamer and inspects every instruction of a decode group in parallel. Each instruction is placed in one of three classes: ordinary, zero-producing (its result is always zero no matter what the registers hold), or register copy (its result equals one source register). The renamer can then bind a zero-producing destination to the hard-wired zero register, and point a copy's destination at wherever the copied register's live value currently resides. Dependent instructions can then issue as soon as the copied value is ready.

Recognition works on ordinary integer add, xor, and, and or instructions; no dedicated move opcode is required. Subtracts reach this block already rewritten as adds. Each slot carries an opcode class, a destination index, two source indices, an immediate-valid flag and an immediate. The second operand is the immediate when the flag is set, and the second source register otherwise. The block is purely combinational. It renames nothing, allocates nothing and never drops an instruction.

Top module: `idiom_detect`

## Requirements
- R1: The 3-bit opcode class is encoded as 0 other, 1 add, 2 xor, 3 and, 4 or, and 5 to 7 also other. Any slot whose class is not add, xor, and or or is reported as ordinary. The 2-bit result class is 00 ordinary, 01 zero, 10 move, and is never 11.
- R2: A slot whose destination index is 0 is reported as ordinary, whatever its opcode and operands.
- R3: An add with first source 0, the immediate-valid flag set and immediate 0 is reported as zero.
- R4: An xor in register form (immediate-valid clear) whose two source indices are equal is reported as zero.
- R5: An and whose first source is 0, or whose second operand is zero (immediate 0 when valid, second source 0 otherwise), is reported as zero.
- R6: An add, or or xor whose two operands are both zero is reported as zero and not as a move.
- R7: An add, or or xor whose second operand is zero and whose first source is nonzero is reported as move, with the first source index as the move source.
- R8: An add, or or xor in register form whose first source is 0 and whose second source is nonzero is reported as move, with the second source index as the move source.
- R9: An add, or or xor whose first source is 0 and whose nonzero immediate is valid is reported as ordinary.
- R10: The 5-bit move source output of a slot is 0 whenever that slot is not reported as move.
- R11: Every slot is classified from its own inputs alone, and results follow the inputs within the same cycle with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_cls_i | input | SLOTS*3 | Opcode class per slot, slot k at bits [3k+2:3k] |
| rd_i | input | SLOTS*5 | Destination register index per slot |
| rs1_i | input | SLOTS*5 | First source register index per slot |
| rs2_i | input | SLOTS*5 | Second source register index per slot |
| imm_vld_i | input | SLOTS | Second operand is the immediate when set |
| imm_i | input | SLOTS*IMM_W | Immediate per slot |
| kind_o | output | SLOTS*2 | Result class per slot: 00 ordinary, 01 zero, 10 move |
| mov_src_o | output | SLOTS*5 | Copied register index per slot, 0 unless move |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench therefore drives a full decode group on the falling clock edge and compares each slot one nanosecond later, well before the next rising edge. Slots in the same group are given unrelated patterns, so a fault that leaks between slots produces a mismatch in a neighbour. A behavioural model in the bench computes the expected class and source for each slot in each cycle.

// File: rtl/idiom_pkg.sv
// Package: shared encodings for the zero/move idiom detector.
// Assumes subtracts were already rewritten as adds upstream.
package idiom_pkg;

    localparam int OP_W  = 3;   // opcode class width
    localparam int REG_W = 5;   // architectural register index width
    localparam int CLS_W = 2;   // result class width

    typedef enum logic [OP_W-1:0] {
        OPC_OTHER = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_XOR   = 3'd2,
        OPC_AND   = 3'd3,
        OPC_OR    = 3'd4
    } opc_e;

    typedef enum logic [CLS_W-1:0] {
        KIND_ORD  = 2'b00,
        KIND_ZERO = 2'b01,
        KIND_MOVE = 2'b10
    } kind_e;

endpackage

// File: rtl/idiom_operand_zero.sv
// Module: idiom_operand_zero
// Derives per-operand facts for one slot: whether each operand is zero,
// whether the second operand is a register, and whether both sources name
// the same register in register form. Purely combinational.
module idiom_operand_zero
    import idiom_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [REG_W-1:0] rs1_i,
    input  logic [REG_W-1:0] rs2_i,
    input  logic             imm_vld_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic             a_zero_o,
    output logic             b_zero_o,
    output logic             b_is_reg_o,
    output logic             same_reg_o
);

    // Zero tests on each operand; the second operand selects immediate or register.
    always_comb begin
        a_zero_o   = (rs1_i == '0);
        b_is_reg_o = ~imm_vld_i;
        b_zero_o   = imm_vld_i ? (imm_i == '0) : (rs2_i == '0);
        same_reg_o = ~imm_vld_i & (rs1_i == rs2_i);
    end

endmodule

// File: rtl/idiom_slot_classify.sv
// Module: idiom_slot_classify
// Classifies a single decoded instruction as ordinary, zero-producing or
// register copy, and reports the copied register. Assumes the opcode class
// encoding of idiom_pkg. Purely combinational.
module idiom_slot_classify
    import idiom_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [REG_W-1:0] rd_i,
    input  logic [REG_W-1:0] rs1_i,
    input  logic [REG_W-1:0] rs2_i,
    input  logic             imm_vld_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [CLS_W-1:0] kind_o,
    output logic [REG_W-1:0] src_o
);

    logic a_zero, b_zero, b_is_reg, same_reg;
    logic both_zero, only_b_zero, only_a_zero;
    opc_e opc;
    kind_e kind;

    idiom_operand_zero #(.IMM_W(IMM_W)) u_opz (
        .rs1_i      (rs1_i),
        .rs2_i      (rs2_i),
        .imm_vld_i  (imm_vld_i),
        .imm_i      (imm_i),
        .a_zero_o   (a_zero),
        .b_zero_o   (b_zero),
        .b_is_reg_o (b_is_reg),
        .same_reg_o (same_reg)
    );

    // Combine the zero flags into the three shapes that matter.
    always_comb begin
        both_zero   = a_zero & b_zero;
        only_b_zero = b_zero & ~a_zero;
        only_a_zero = a_zero & ~b_zero;
        opc         = opc_e'(op_i);
    end

    // Pick the class and copied register, with zero outranking move.
    always_comb begin
        kind  = KIND_ORD;
        src_o = '0;
        if (rd_i != '0) begin
            case (opc)
                OPC_AND: begin
                    if (a_zero | b_zero) kind = KIND_ZERO;
                end
                OPC_ADD, OPC_XOR, OPC_OR: begin
                    if ((opc == OPC_XOR) && same_reg) begin
                        kind = KIND_ZERO;
                    end else if (both_zero) begin
                        kind = KIND_ZERO;
                    end else if (only_b_zero) begin
                        kind  = KIND_MOVE;
                        src_o = rs1_i;
                    end else if (only_a_zero && b_is_reg) begin
                        kind  = KIND_MOVE;
                        src_o = rs2_i;
                    end
                end
                default: kind = KIND_ORD;
            endcase
        end
        kind_o = kind;
    end

endmodule

// File: rtl/idiom_detect.sv
// Module: idiom_detect (top)
// Runs one classifier per decode slot on flattened slot buses. Slot k
// occupies the k-th field of each bus. No clock, no state, no cross-slot logic.
module idiom_detect
    import idiom_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IMM_W = 12
) (
    input  logic [SLOTS*OP_W-1:0]  op_cls_i,
    input  logic [SLOTS*REG_W-1:0] rd_i,
    input  logic [SLOTS*REG_W-1:0] rs1_i,
    input  logic [SLOTS*REG_W-1:0] rs2_i,
    input  logic [SLOTS-1:0]       imm_vld_i,
    input  logic [SLOTS*IMM_W-1:0] imm_i,
    output logic [SLOTS*CLS_W-1:0] kind_o,
    output logic [SLOTS*REG_W-1:0] mov_src_o
);

    // One independent classifier per slot.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        idiom_slot_classify #(.IMM_W(IMM_W)) u_cls (
            .op_i      (op_cls_i [k*OP_W  +: OP_W]),
            .rd_i      (rd_i     [k*REG_W +: REG_W]),
            .rs1_i     (rs1_i    [k*REG_W +: REG_W]),
            .rs2_i     (rs2_i    [k*REG_W +: REG_W]),
            .imm_vld_i (imm_vld_i[k]),
            .imm_i     (imm_i    [k*IMM_W +: IMM_W]),
            .kind_o    (kind_o   [k*CLS_W +: CLS_W]),
            .src_o     (mov_src_o[k*REG_W +: REG_W])
        );
    end

endmodule

// File: rtl/idiom_detect_chk.sv
// Checker: idiom_detect_chk
// Port-level consistency rules for idiom_detect, evaluated whenever the
// slot buses change. Attached by bind below.
module idiom_detect_chk
    import idiom_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IMM_W = 12
) (
    input logic [SLOTS*OP_W-1:0]  op_cls_i,
    input logic [SLOTS*REG_W-1:0] rd_i,
    input logic [SLOTS*REG_W-1:0] rs1_i,
    input logic [SLOTS*REG_W-1:0] rs2_i,
    input logic [SLOTS-1:0]       imm_vld_i,
    input logic [SLOTS*IMM_W-1:0] imm_i,
    input logic [SLOTS*CLS_W-1:0] kind_o,
    input logic [SLOTS*REG_W-1:0] mov_src_o
);

    // Per-slot rules relating inputs to results.
    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            logic [OP_W-1:0]  op;
            logic [REG_W-1:0] rd, s1, s2, src;
            logic [CLS_W-1:0] kd;
            op  = op_cls_i [k*OP_W  +: OP_W];
            rd  = rd_i     [k*REG_W +: REG_W];
            s1  = rs1_i    [k*REG_W +: REG_W];
            s2  = rs2_i    [k*REG_W +: REG_W];
            kd  = kind_o   [k*CLS_W +: CLS_W];
            src = mov_src_o[k*REG_W +: REG_W];
            assert_kind_legal_R1: assert (kd != 2'b11);
            assert_other_ordinary_R1: assert (!(op == 3'd0 || op > 3'd4) || kd == 2'b00);
            assert_rd_zero_ordinary_R2: assert (rd != '0 || kd == 2'b00);
            assert_xor_self_zero_R4: assert (!(op == 3'd2 && rd != '0 && !imm_vld_i[k] && s1 == s2) || kd == 2'b01);
            assert_and_never_move_R5: assert (op != 3'd3 || kd != 2'b10);
            assert_src_idle_R10: assert (kd == 2'b10 || src == '0);
            assert_move_src_named_R7: assert (kd != 2'b10 || src == s1 || src == s2);
            assert_move_src_nonzero_R8: assert (kd != 2'b10 || src != '0);
        end
    end

endmodule

bind idiom_detect idiom_detect_chk #(.SLOTS(SLOTS), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/idiom_detect_tb.sv
module idiom_detect_tb;

    localparam int SLOTS = 4;
    localparam int IMM_W = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [SLOTS*3-1:0]     op_cls_i;
    logic [SLOTS*5-1:0]     rd_i, rs1_i, rs2_i;
    logic [SLOTS-1:0]       imm_vld_i;
    logic [SLOTS*IMM_W-1:0] imm_i;
    logic [SLOTS*2-1:0]     kind_o;
    logic [SLOTS*5-1:0]     mov_src_o;

    idiom_detect #(.SLOTS(SLOTS), .IMM_W(IMM_W)) u_dut (
        .op_cls_i (op_cls_i), .rd_i (rd_i), .rs1_i (rs1_i), .rs2_i (rs2_i),
        .imm_vld_i(imm_vld_i), .imm_i (imm_i),
        .kind_o   (kind_o), .mov_src_o (mov_src_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int t_op [SLOTS], t_rd [SLOTS], t_s1 [SLOTS], t_s2 [SLOTS], t_iv [SLOTS], t_imm [SLOTS];
    string t_tag [SLOTS];

    // Behavioural model: returns class (0 ord, 1 zero, 2 move), source and the requirement tag.
    task automatic model(input int op, rd, s1, s2, iv, imm,
                         output int kind, output int src, output string tag);
        bit za, zb;
        kind = 0; src = 0; tag = "R1";
        za = (s1 == 0);
        zb = iv ? (imm == 0) : (s2 == 0);
        if (rd == 0) begin tag = "R2"; return; end
        if (op == 3) begin
            tag = "R5";
            if (za || zb) kind = 1;
            return;
        end
        if (op != 1 && op != 2 && op != 4) return;
        if (op == 2 && !iv && s1 == s2) begin kind = 1; tag = "R4"; return; end
        if (za && zb) begin kind = 1; tag = (op == 1 && iv) ? "R3" : "R6"; return; end
        if (zb) begin kind = 2; src = s1; tag = "R7"; return; end
        if (za && !iv) begin kind = 2; src = s2; tag = "R8"; return; end
        if (za) begin tag = "R9"; return; end
        tag = "R11";
    endtask

    task automatic set_slot(input int k, op, rd, s1, s2, iv, imm, input string tag);
        t_op[k] = op; t_rd[k] = rd; t_s1[k] = s1; t_s2[k] = s2;
        t_iv[k] = iv; t_imm[k] = imm; t_tag[k] = tag;
    endtask

    // Drive all slots on the falling edge, compare 1 ns later (same cycle).
    task automatic apply_and_check();
        @(negedge clk);
        for (int k = 0; k < SLOTS; k++) begin
            op_cls_i [k*3 +: 3]         = 3'(t_op[k]);
            rd_i     [k*5 +: 5]         = 5'(t_rd[k]);
            rs1_i    [k*5 +: 5]         = 5'(t_s1[k]);
            rs2_i    [k*5 +: 5]         = 5'(t_s2[k]);
            imm_vld_i[k]                = t_iv[k][0];
            imm_i    [k*IMM_W +: IMM_W] = IMM_W'(t_imm[k]);
        end
        #1;
        for (int k = 0; k < SLOTS; k++) begin
            int ek, es, ak, as_;
            string mt;
            model(t_op[k], t_rd[k], t_s1[k], t_s2[k], t_iv[k], t_imm[k], ek, es, mt);
            ak  = int'(kind_o[k*2 +: 2]);
            as_ = int'(mov_src_o[k*5 +: 5]);
            checks++;
            if (ak != ek) begin
                failures++;
                $display("FAIL %s/%s slot %0d kind actual=%0d expected=%0d", t_tag[k], mt, k, ak, ek);
            end
            checks++;
            if (as_ != es) begin
                failures++;
                $display("FAIL %s/R10 slot %0d src actual=%0d expected=%0d", t_tag[k], k, as_, es);
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        op_cls_i = '0; rd_i = '0; rs1_i = '0; rs2_i = '0; imm_vld_i = '0; imm_i = '0;
        // Idle state: all-zero inputs give ordinary everywhere (R2, R10).
        for (int k = 0; k < SLOTS; k++) set_slot(k, 0, 0, 0, 0, 0, 0, "R2");
        apply_and_check();
        // li-zero, xor self, and with x0, rd x0 xor self
        set_slot(0, 1, 10, 0, 7, 1, 0, "R3");
        set_slot(1, 2, 5, 9, 9, 0, 0, "R4");
        set_slot(2, 3, 6, 0, 8, 0, 0, "R5");
        set_slot(3, 2, 0, 9, 9, 0, 0, "R2");
        apply_and_check();
        // moves of each kind plus and-imm-zero
        set_slot(0, 1, 10, 11, 0, 1, 0, "R7");
        set_slot(1, 4, 12, 0, 13, 0, 0, "R8");
        set_slot(2, 2, 14, 15, 0, 0, 0, "R7");
        set_slot(3, 3, 6, 4, 0, 1, 0, "R5");
        apply_and_check();
        // both zero, li nonzero, other opcodes
        set_slot(0, 4, 10, 0, 0, 0, 0, "R6");
        set_slot(1, 1, 12, 0, 0, 1, 5, "R9");
        set_slot(2, 5, 14, 15, 0, 0, 0, "R1");
        set_slot(3, 0, 6, 4, 0, 1, 0, "R1");
        apply_and_check();
        // xor-imm with equal regs is not self-xor; and nonzero operands; op 7
        set_slot(0, 2, 3, 4, 4, 1, 9, "R4");
        set_slot(1, 3, 3, 4, 5, 0, 0, "R5");
        set_slot(2, 7, 3, 0, 0, 1, 0, "R1");
        set_slot(3, 1, 31, 31, 2, 1, 4095, "R11");
        apply_and_check();
        // Random groups mixing small indices and immediates (R11).
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < SLOTS; k++)
                set_slot(k, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                         int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                         int'($urandom_range(0, 1)), int'($urandom_range(0, 2)), "R11");
            apply_and_check();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule